// File: doc/BRIEF.md
# Fractional-Baud Asynchronous Receiver

This block takes a single asynchronous serial line and assembles words of 1 to 32 data bits. Each word starts with a low start bit, and the data bits arrive least significant first. The bit period comes from a configuration word in 16.6 fixed point, so rates that are not a whole number of clocks per bit are followed with no drift. The timer works in 1/64-clock units and carries the fractional remainder from one bit to the next.

Once a start edge is seen, the receiver checks that the line is still low half a bit period later, so a short low pulse is dropped as a glitch. It then samples one bit per bit period into a register that shifts right, with each new bit entering at the top. After the last bit, the shifter is copied to the result register and an event flag is raised. The word sits in the upper bits of the 32-bit result, so software shifts it right by 32 minus the word length. The flag stays set until software acknowledges it. A new word replaces the result whether or not the old one was read.

Top module: `frac_uart_rx`

## Requirements
- R1: While rst_n is low, data_o is 0 and event_o is 0. After reset the receiver waits for the synchronized line to be high before it accepts a start.
- R2: The bit period P, in 1/64-clock units, is cfg_i[31:16]*64 + cfg_i[15:10] when cfg_i[31:26] is zero, and cfg_i[31:16]*64 otherwise. cfg_i is taken at start detection. Periods of at least two clocks are supported.
- R3: The word length L is cfg_i[4:0]+1, from 1 to 32 bits, taken at start detection.
- R4: rx_i passes through two register stages before use. A start is accepted only when the synchronized line is seen low after it has been seen high, both at reset and after each word.
- R5: Define edge 0 as the clock edge at which the receiver, waiting for a start, sees the synchronized line low. At the first edge k ≥ 1 with 64k ≥ floor(P/2), the line must still be low. If it is high, no word is produced, data_o keeps its value, and the receiver waits for a new start.
- R6: Data bit n (n = 1..L) is sampled at the first edge k with 64k ≥ floor(P/2) + n·P. Each sample is shifted in at bit 31 of a right-shifting register that is cleared at start. After the word, data_o[31:32-L] holds the word with its first bit at the lowest of those positions, and data_o[31-L:0] is zero.
- R7: data_o and event_o take their new values one clock after the last data sample. The receiver then waits for idle high again. A new word overwrites data_o even if event_o is still set.
- R8: event_o stays high until a cycle with ack_i high clears it. If ack_i is high in the same cycle as a capture, the flag is still set. ack_i has no effect on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Bit period (whole [31:16], fraction [15:10]) and word length minus one [4:0] |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| ack_i | input | 1 | Clears the word-ready flag |
| data_o | output | 32 | Last received word, MSB-justified |
| event_o | output | 1 | Word-ready flag |

## Verification
A behavioural timing model in the bench predicts data_o and event_o every cycle. It catches a fractional remainder that is dropped or applied when the guard bits are set: over a 32-bit word at 7.5 clocks per bit, or on a 1024-clock period, the capture cycle moves. The bench holds the line low out of reset and sends a short low pulse. A receiver that skips the idle-high wait or the mid-start check would then capture a junk word. Single-bit and 32-bit words test the bit counter and the MSB justification at both extremes. A back-to-back overwrite and an acknowledge held through a whole reception show whether the flag logic resolves capture against clear the wrong way.

// File: rtl/frac_uart_rx_pkg.sv
package frac_uart_rx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        RX_WAIT_IDLE  = 2'd0,
        RX_WAIT_START = 2'd1,
        RX_CHECK      = 2'd2,
        RX_DATA       = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    // Reset to low so a line held low out of reset is never taken as idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_period_decode.sv
module rx_period_decode #(
    parameter int CFG_W   = 32,
    parameter int WHOLE_W = 16,
    parameter int FRAC_W  = 6,
    parameter int LEN_W   = 5,
    localparam int PER_W     = WHOLE_W + FRAC_W,
    localparam int WHOLE_LSB = CFG_W - WHOLE_W,
    localparam int FRAC_LSB  = WHOLE_LSB - FRAC_W
) (
    input  logic [CFG_W-1:0] cfg_i,
    output logic [PER_W-1:0] period_o,
    output logic [LEN_W-1:0] last_o
);

    logic [WHOLE_W-1:0] whole;
    logic [FRAC_W-1:0]  guard;
    logic [FRAC_W-1:0]  frac;
    logic               unused_cfg;

    always_comb begin
        whole    = cfg_i[CFG_W-1:WHOLE_LSB];
        guard    = cfg_i[CFG_W-1 -: FRAC_W];
        // fraction only counts while the whole part is small enough
        frac     = (guard == '0) ? cfg_i[FRAC_LSB +: FRAC_W] : '0;
        period_o = {whole, frac};
        last_o   = cfg_i[LEN_W-1:0];
    end

    assign unused_cfg = ^cfg_i[FRAC_LSB-1:LEN_W];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int PER_W  = 22,
    parameter int FRAC_W = 6,
    localparam int REM_W = PER_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PER_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);

    localparam logic signed [REM_W-1:0] ONE_CLK = REM_W'(1) << FRAC_W;

    logic signed [REM_W-1:0] rem_d, rem_q;
    logic signed [REM_W-1:0] per_s;

    always_comb begin
        per_s  = $signed({2'b00, period_i});
        // fire in the first clock whose end reaches the remaining time
        tick_o = run_i && (rem_q <= ONE_CLK);
        rem_d  = rem_q;
        if (load_i) begin
            rem_d = $signed({2'b00, load_val_i});
        end else if (run_i) begin
            if (tick_o) rem_d = rem_q - ONE_CLK + per_s;
            else        rem_d = rem_q - ONE_CLK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx #(
    parameter int WORD_W      = 32,
    parameter int WHOLE_W     = 16,
    parameter int FRAC_W      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W = 32,
    localparam int LEN_W = $clog2(WORD_W),
    localparam int PER_W = WHOLE_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              rx_i,
    input  logic              ack_i,
    output logic [WORD_W-1:0] data_o,
    output logic              event_o
);
    import frac_uart_rx_pkg::*;

    typedef struct packed {
        rx_state_e         state;
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] result;
        logic              event_f;
        logic [PER_W-1:0]  period;
        logic [LEN_W-1:0]  last;
        logic [LEN_W-1:0]  count;
    } rx_regs_t;

    localparam rx_regs_t REGS_RESET = '{
        state:   RX_WAIT_IDLE,
        shift:   '0,
        result:  '0,
        event_f: 1'b0,
        period:  '0,
        last:    '0,
        count:   '0
    };

    rx_regs_t st_d, st_q;

    logic             line;
    logic [PER_W-1:0] dec_period;
    logic [LEN_W-1:0] dec_last;
    logic             tmr_load;
    logic [PER_W-1:0] tmr_load_val;
    logic             tmr_run;
    logic             tick;
    logic [WORD_W-1:0] shift_next;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (line)
    );

    rx_period_decode #(
        .CFG_W   (CFG_W),
        .WHOLE_W (WHOLE_W),
        .FRAC_W  (FRAC_W),
        .LEN_W   (LEN_W)
    ) u_decode (
        .cfg_i    (cfg_i),
        .period_o (dec_period),
        .last_o   (dec_last)
    );

    rx_bit_timer #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_load_val),
        .run_i      (tmr_run),
        .period_i   (st_q.period),
        .tick_o     (tick)
    );

    always_comb begin
        st_d         = st_q;
        tmr_load     = 1'b0;
        tmr_load_val = dec_period >> 1;
        tmr_run      = (st_q.state == RX_CHECK) || (st_q.state == RX_DATA);
        shift_next   = {line, st_q.shift[WORD_W-1:1]};

        // acknowledge first, so a capture in the same cycle wins
        if (ack_i) st_d.event_f = 1'b0;

        unique case (st_q.state)
            RX_WAIT_IDLE: begin
                if (line) st_d.state = RX_WAIT_START;
            end
            RX_WAIT_START: begin
                if (!line) begin
                    st_d.state  = RX_CHECK;
                    st_d.period = dec_period;
                    st_d.last   = dec_last;
                    st_d.count  = '0;
                    st_d.shift  = '0;
                    tmr_load    = 1'b1;
                end
            end
            RX_CHECK: begin
                if (tick) begin
                    if (line) st_d.state = RX_WAIT_START;
                    else      st_d.state = RX_DATA;
                end
            end
            RX_DATA: begin
                if (tick) begin
                    st_d.shift = shift_next;
                    if (st_q.count == st_q.last) begin
                        st_d.result  = shift_next;
                        st_d.event_f = 1'b1;
                        st_d.state   = RX_WAIT_IDLE;
                    end else begin
                        st_d.count = st_q.count + 1'b1;
                    end
                end
            end
            default: st_d.state = RX_WAIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RESET;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.result;
    assign event_o = st_q.event_f;

endmodule

// File: rtl/frac_uart_rx_chk.sv
module frac_uart_rx_chk #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic [WORD_W-1:0] data_o,
    input logic              event_o,
    input logic [LEN_W-1:0]  last_len,
    input logic              in_data
);

    // R7
    data_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> event_o);

    // R7
    event_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> $past(in_data));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(event_o) |-> $past(ack_i));

    // R8
    event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !ack_i) |=> event_o);

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> ((data_o << ({1'b0, last_len} + 1'b1)) == '0));

endmodule

bind frac_uart_rx frac_uart_rx_chk #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .data_o   (data_o),
    .event_o  (event_o),
    .last_len (st_q.last),
    .in_data  (st_q.state == frac_uart_rx_pkg::RX_DATA)
);

// File: tb/sim_frac_uart_rx.sv
module sim_frac_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] cfg = '0;
    logic [31:0] data_o;
    logic        event_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit cnt_en = 1'b0;
    int ev_hi = 0;

    frac_uart_rx u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_i   (cfg),
        .rx_i    (rx),
        .ack_i   (ack),
        .data_o  (data_o),
        .event_o (event_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit          m_s1, m_s2, m_old, m_ev;
    int          m_mode, m_c, m_n, m_P, m_len;
    logic [31:0] m_shift, m_res;

    function automatic int period_of(logic [31:0] c);
        int whole = int'(c[31:16]);
        if (c[31:26] == 6'd0) return whole * 64 + int'(c[15:10]);
        return whole * 64;
    endfunction

    function automatic int due(int n);
        int t = m_P / 2 + n * m_P;
        int k = (t + 63) / 64;
        return (k < 1) ? 1 : k;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ev = 0; m_mode = 0;
            m_shift = '0; m_res = '0; m_c = 0; m_n = 0;
        end else begin
            m_old = m_s2;
            if (ack) m_ev = 0;
            case (m_mode)
                0: if (m_old) m_mode = 1;
                1: if (!m_old) begin
                       m_P = period_of(cfg);
                       m_len = int'(cfg[4:0]) + 1;
                       m_c = 0; m_n = 0; m_shift = '0; m_mode = 2;
                   end
                default: begin
                    m_c++;
                    if (m_c == due(m_n)) begin
                        if (m_n == 0) begin
                            if (m_old) m_mode = 1;
                            else m_n = 1;
                        end else begin
                            m_shift = {m_old, m_shift[31:1]};
                            if (m_n == m_len) begin
                                m_res = m_shift; m_ev = 1; m_mode = 0;
                            end else m_n++;
                        end
                    end
                end
            endcase
            m_s2 = m_s1;
            m_s1 = rx;
        end
    end

    // per-cycle comparison against the reference (R6, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (data_o !== m_res) begin
                miscompares++;
                $display("FAIL R6 data_o cycle %0d: actual %h expected %h", cycles, data_o, m_res);
            end
            if (event_o !== m_ev) begin
                miscompares++;
                $display("FAIL R8 event_o cycle %0d: actual %0d expected %0d", cycles, event_o, m_ev);
            end
            if (cnt_en && event_o) ev_hi++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] val, input int len, input int p64);
        int total = ((len + 2) * p64 + 63) / 64;
        for (int i = 0; i < total; i++) begin
            int pos = (i * 64) / p64;
            if (pos == 0)        rx = 1'b0;
            else if (pos <= len) rx = val[pos-1];
            else                 rx = 1'b1;
            @(negedge clk);
        end
        rx = 1'b1;
        idle(4);
    endtask

    task automatic word_ok(input logic [31:0] val, input int len, input string tag);
        logic [31:0] msk = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
        logic [31:0] low = (len == 32) ? 32'h0 : ((32'h1 << (32 - len)) - 1);
        chk(event_o == 1'b1, {tag, " event after word"}, event_o, 1);
        chk((data_o >> (32 - len)) == (val & msk), {tag, " justified word"}, data_o >> (32 - len), val & msk);
        chk((data_o & low) == 0, {"R6 ", tag, " low bits zero"}, data_o & low, 0);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    function automatic logic [31:0] mkcfg(input int whole, input int frac, input int len);
        return {whole[15:0], frac[5:0], 5'd0, 5'(len - 1)};
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] held;
        idle(4);
        // R1 reset state
        chk(data_o == 0, "R1 data_o in reset", data_o, 0);
        chk(event_o == 0, "R1 event_o in reset", event_o, 0);
        rst_n = 1'b1;
        // R4 line low out of reset must not start a word
        idle(40);
        chk(event_o == 0, "R4 no word while line stuck low", event_o, 0);
        rx = 1'b1;
        idle(10);

        // R3 R6 eight bits at eight clocks
        cfg = mkcfg(8, 0, 8);
        send(32'hA5, 8, 8 * 64);
        word_ok(32'hA5, 8, "R3");
        // R8 flag holds, then clears on ack
        idle(10);
        chk(event_o == 1, "R8 flag held without ack", event_o, 1);
        pulse_ack();
        chk(event_o == 0, "R8 flag cleared by ack", event_o, 0);
        held = data_o;
        pulse_ack();
        chk(data_o == held, "R8 ack leaves data_o", data_o, held);

        // R2 fractional 7.5 clocks, 32-bit word
        cfg = 32'h0007_8000 | 32'd31;
        send(32'hDEAD_BEEF, 32, 480);
        word_ok(32'hDEAD_BEEF, 32, "R2");
        pulse_ack();

        // R3 single-bit words
        cfg = mkcfg(10, 0, 1);
        send(32'h1, 1, 640);
        word_ok(32'h1, 1, "R3");
        pulse_ack();
        send(32'h0, 1, 640);
        word_ok(32'h0, 1, "R3");
        pulse_ack();

        // R7 overwrite without ack
        cfg = mkcfg(9, 0, 12);
        send(32'hABC, 12, 576);
        send(32'h123, 12, 576);
        word_ok(32'h123, 12, "R7");
        pulse_ack();

        // R5 glitch: short low pulse, no word
        cfg = mkcfg(16, 0, 8);
        held = data_o;
        rx = 1'b0; idle(3); rx = 1'b1;
        idle(40);
        chk(event_o == 0, "R5 glitch makes no word", event_o, 0);
        chk(data_o == held, "R5 glitch keeps data_o", data_o, held);
        send(32'h3C, 8, 16 * 64);
        word_ok(32'h3C, 8, "R5");
        pulse_ack();

        // R2 fraction ignored when guard bits set (period 1024 clocks)
        cfg = mkcfg(16'h0400, 6'h3F, 1);
        send(32'h1, 1, 1024 * 64);
        word_ok(32'h1, 1, "R2");
        pulse_ack();

        // R8 capture wins over an ack held through reception
        cfg = mkcfg(8, 0, 8);
        ack = 1'b1;
        ev_hi = 0;
        cnt_en = 1'b1;
        send(32'h5A, 8, 512);
        idle(4);
        cnt_en = 1'b0;
        ack = 1'b0;
        chk(ev_hi == 1, "R8 flag high one cycle under held ack", ev_hi, 1);

        // R6 assorted lengths and fractional periods
        for (int k = 0; k < 6; k++) begin
            int len  = 3 + k * 5;
            int frac = (k * 13) % 64;
            int whole = 8 + k;
            logic [31:0] v = 32'h9E37_79B9 * (k + 1);
            cfg = mkcfg(whole, frac, len);
            send(v, len, whole * 64 + frac);
            word_ok(v, len, "R6");
            pulse_ack();
        end

        idle(10);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule